// File: doc/BRIEF.md
# Random Byte Pool Register Interface

This block gathers random bytes from an entropy source into a small first-in first-out pool and hands them to software through a single 32-bit control and status register. The source is an 8-bit byte input qualified by a one-cycle valid strobe. A parameter can replace that input with an internal 16-bit linear feedback shift register, which gives repeatable data in simulation. A status bit reports when this mode is in use.

Bytes enter the pool on their own whenever the block is enabled and the pool has room. Each register read consumes the byte it returns, so software never sees the same byte twice. Software can empty the pool with a self-clearing flush command. Clearing the enable bit also empties the pool.

The bus side has a single-cycle read strobe, a single-cycle write strobe and an address that is compared against a parameter. Read data is combinational from the current state while the read strobe is high. The pop, flush and enable update take effect at the clock edge that ends the access.

Top module: `rndpool_regif`

## Requirements
- R1: The register answers only when `bus_addr` equals `REG_ADDR`. Its fields are: byte in bits 7:0, flush command in bit 28, simulation flag in bit 29, enable in bit 30, valid in bit 31. Outside a matching read, `bus_rdata` is all zero.
- R2: Bits 7:0 read as zero in any read where bit 31 (valid) reads zero.
- R3: A matching read of a non-empty pool returns the oldest byte with bit 31 set and removes that byte. The next read returns the following byte, or valid clear if no byte is held.
- R4: Bit 28 always reads zero. Writing it as one empties the pool at that clock edge, and a source byte offered in the same cycle is dropped.
- R5: Bit 30 is read/write. While it holds zero the pool is emptied every cycle and no source byte is accepted, including in the cycle of the write that sets it again.
- R6: Source bytes are accepted in arrival order until `DEPTH` bytes are held (DEPTH a power of two, at least 1). Bytes that arrive while the pool is full and no read occurs are dropped.
- R7: When a matching read and a source byte occur in the same cycle with the pool full, the read returns the oldest byte and the new byte takes the freed slot.
- R8: After reset, bit 30 and bit 31 are zero and the pool is empty.
- R9: With `SIM_SRC`=1, bit 29 reads one and the byte inputs are ignored. A 16-bit LFSR starts at `SEED` and, while enabled, shifts left once per cycle, taking in the XOR of bits 15, 13, 12 and 10. A 3-bit counter, cleared while disabled, counts each enabled cycle. When it reads 7, the LFSR's low byte is offered to the pool in that cycle. With `SIM_SRC`=0, bit 29 reads zero.
- R10: Writes to bits 31, 29 and 27:0 have no effect, and bits 27:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Access address, compared against REG_ADDR |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside a matching read |
| ent_valid | input | 1 | Source byte strobe |
| ent_byte | input | 8 | Source byte |

## Verification
The hardest situation to reach is a full pool that receives a read and a new source byte in the same cycle. The same holds for a flush or a disable that meets an incoming byte, because each needs the pool's fill level and several strobes to line up in one cycle. Directed sequences fill the pool to its depth and then fire these coincidences on purpose. A long seeded random run with frequent reads, frequent source strobes and rare control writes then mixes them with other states. A second instance in LFSR mode, with a depth of one, sees the same bus traffic and is checked against a bench model of the shift register.

// File: rtl/rndpool_pkg.sv
package rndpool_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned POS_FLUSH = 28;
   localparam int unsigned POS_SIM   = 29;
   localparam int unsigned POS_EN    = 30;
   localparam int unsigned POS_VALID = 31;
   localparam int unsigned LFSR_W    = 16;
endpackage

// File: rtl/rndpool_lfsr.sv
module rndpool_lfsr #(
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter int unsigned PERIOD_LG = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   output logic       src_valid,
   output logic [7:0] src_byte
);
   import rndpool_pkg::*;

   logic [LFSR_W-1:0]    state;
   logic [PERIOD_LG-1:0] phase;
   logic                 fb;

   assign fb        = state[15] ^ state[13] ^ state[12] ^ state[10];
   assign src_valid = run && (phase == {PERIOD_LG{1'b1}});
   assign src_byte  = state[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
         phase <= '0;
      end else if (run) begin
         state <= {state[LFSR_W-2:0], fb};
         phase <= phase + 1'b1;
      end else begin
         phase <= '0;
      end
   end
endmodule

// File: rtl/rndpool_fifo.sv
module rndpool_fifo #(
   parameter int unsigned DEPTH = 1,
   parameter int unsigned W     = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   generate
      if (DEPTH == 1) begin : g_hold
         logic [W-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      count <= '0;
            else if (clr)    count <= '0;
            else if (push)   count <= 1'b1;
            else if (pop)    count <= '0;
         end
         always_ff @(posedge clk) begin
            if (push && !clr) hold <= wdata;
         end
         assign rdata = hold;
      end else begin : g_ring
         localparam int unsigned PTR_W = $clog2(DEPTH);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp, rp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp    <= '0;
               rp    <= '0;
               count <= '0;
            end else if (clr) begin
               wp    <= '0;
               rp    <= '0;
               count <= '0;
            end else begin
               if (push) wp <= wp + 1'b1;
               if (pop)  rp <= rp + 1'b1;
               count <= count + CNT_W'(push) - CNT_W'(pop);
            end
         end
         always_ff @(posedge clk) begin
            if (push && !clr) mem[wp] <= wdata;
         end
         assign rdata = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/rndpool_regif.sv
module rndpool_regif #(
   parameter int unsigned DEPTH    = 1,
   parameter bit          SIM_SRC  = 1'b0,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter int unsigned ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ent_valid,
   input  logic [7:0]        ent_byte
);
   import rndpool_pkg::*;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic              hit_rd, hit_wr, flush_wr;
   logic              en, clr, push, pop;
   logic              src_v;
   logic [BYTE_W-1:0] src_b, head;
   logic [CNT_W-1:0]  pool_cnt;
   logic              pool_full, pool_empty;
   logic              unused_wbits;

   assign hit_rd   = bus_rd && (bus_addr == REG_ADDR);
   assign hit_wr   = bus_wr && (bus_addr == REG_ADDR);
   assign flush_wr = hit_wr && bus_wdata[POS_FLUSH];
   assign clr      = flush_wr || !en;
   assign pop      = hit_rd && !pool_empty;
   assign push     = src_v && en && !flush_wr && (!pool_full || pop);
   assign unused_wbits = ^{bus_wdata[31], bus_wdata[29], bus_wdata[27:0]};

   generate
      if (SIM_SRC) begin : g_sim_src
         logic unused_ent;
         assign unused_ent = ^{ent_valid, ent_byte};
         rndpool_lfsr #(.SEED(SEED), .PERIOD_LG(3)) u_lfsr (
            .clk(clk), .rst_n(rst_n), .run(en),
            .src_valid(src_v), .src_byte(src_b)
         );
      end else begin : g_ext_src
         assign src_v = ent_valid;
         assign src_b = ent_byte;
      end
   endgenerate

   rndpool_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_pool (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
      .wdata(src_b), .rdata(head), .count(pool_cnt),
      .full(pool_full), .empty(pool_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (hit_wr) en <= bus_wdata[POS_EN];
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_rd) begin
         bus_rdata[POS_VALID] = !pool_empty;
         bus_rdata[POS_EN]    = en;
         bus_rdata[POS_SIM]   = SIM_SRC;
         bus_rdata[BYTE_W-1:0] = pool_empty ? '0 : head;
      end
   end
endmodule

module rndpool_regif_chk #(
   parameter int unsigned DEPTH   = 1,
   parameter bit          SIM_SRC = 1'b0,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             clr,
   input logic             push,
   input logic             pop,
   input logic             hit_rd,
   input logic [CNT_W-1:0] pool_cnt,
   input logic [31:0]      bus_rdata
);
   generate
      if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 1");
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pool_cnt <= CNT_W'(DEPTH)); // R6
   AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[31] |-> bus_rdata[7:0] == 8'h00); // R2
   AST_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr) |=> pool_cnt == $past(pool_cnt) - CNT_W'(1)); // R3
   AST_FLUSH_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[28]); // R4
   AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> pool_cnt == '0); // R5
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && push && pool_cnt == CNT_W'(DEPTH)) |=> pool_cnt == CNT_W'(DEPTH)); // R7
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[27:8] == 20'h0); // R10
   AST_SIM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      hit_rd |-> bus_rdata[29] == SIM_SRC); // R9
endmodule

bind rndpool_regif rndpool_regif_chk #(.DEPTH(DEPTH), .SIM_SRC(SIM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .push(push), .pop(pop),
   .hit_rd(hit_rd), .pool_cnt(pool_cnt), .bus_rdata(bus_rdata)
);

// File: tb/rndpool_regif_bench.sv
module rndpool_regif_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] REG = 4'h6;
   localparam logic [15:0] SEED = 16'hACE1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        ent_valid = 1'b0;
   logic [7:0]  ent_byte = '0;
   logic [31:0] rdata_a, rdata_b;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [7:0] qa[$], qb[$];
   bit         ena = 0, enb = 0;
   logic [15:0] ls = SEED;
   logic [2:0]  lc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rndpool_regif #(.DEPTH(4), .SIM_SRC(1'b0), .SEED(SEED), .ADDR_W(4), .REG_ADDR(REG)) u_rndpool_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .ent_valid(ent_valid), .ent_byte(ent_byte));

   rndpool_regif #(.DEPTH(1), .SIM_SRC(1'b1), .SEED(SEED), .ADDR_W(4), .REG_ADDR(REG)) u_rndpool_regif_sim (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .ent_valid(ent_valid), .ent_byte(ent_byte));

   function automatic logic [31:0] exp_word(bit hit, bit has, bit en, bit sim, logic [7:0] head);
      logic [31:0] w = '0;
      if (hit) begin
         w[31] = has; w[30] = en; w[29] = sim;
         w[7:0] = has ? head : 8'h00;
      end
      return w;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string who);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
      end
   endtask

   task automatic step(input bit rd, input bit wr, input logic [3:0] addr, input logic [31:0] wd,
                       input bit ev, input logic [7:0] eb, input string tag);
      bit hit_r, hit_w, fl, sv;
      logic [7:0] sb;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      ent_valid = ev; ent_byte = eb;
      #1;
      hit_r = rd && addr == REG;
      hit_w = wr && addr == REG;
      fl    = hit_w && wd[28];
      chk(rdata_a, exp_word(hit_r, qa.size() > 0, ena, 1'b0, qa.size() > 0 ? qa[0] : 8'h00), tag, "ext");
      chk(rdata_b, exp_word(hit_r, qb.size() > 0, enb, 1'b1, qb.size() > 0 ? qb[0] : 8'h00), tag, "sim");
      // pool model, external source
      if (!ena || fl) qa.delete();
      else begin
         if (hit_r && qa.size() > 0) void'(qa.pop_front());
         if (ev && qa.size() < 4) qa.push_back(eb);
      end
      // pool model, LFSR source (R9)
      sv = enb && lc == 3'd7;
      sb = ls[7:0];
      if (!enb || fl) qb.delete();
      else begin
         if (hit_r && qb.size() > 0) void'(qb.pop_front());
         if (sv && qb.size() < 1) qb.push_back(sb);
      end
      if (enb) begin
         ls = {ls[14:0], ls[15] ^ ls[13] ^ ls[12] ^ ls[10]};
         lc = lc + 3'd1;
      end else lc = '0;
      if (hit_w) begin ena = wd[30]; enb = wd[30]; end
   endtask

   task automatic idle(input string tag);
      step(0, 0, REG, 32'h0, 0, 8'h00, tag);
   endtask
   task automatic rd_reg(input string tag);
      step(1, 0, REG, 32'h0, 0, 8'h00, tag);
   endtask
   task automatic wr_reg(input logic [31:0] wd, input string tag);
      step(0, 1, REG, wd, 0, 8'h00, tag);
   endtask
   task automatic feed(input logic [7:0] b, input string tag);
      step(0, 0, REG, 32'h0, 1, b, tag);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R8: reset state
      rd_reg("R8");
      // R1: address miss reads zero
      step(1, 0, 4'h5, 32'h0, 0, 8'h00, "R1");
      // R10: set enable while poking read-only and reserved bits
      wr_reg(32'hEFFF_FFFF, "R10");
      rd_reg("R10");
      // R6: overfill, R3: consume in order, R2: empty reads zero data
      for (int i = 0; i < 5; i++) feed(8'h11 + 8'(i), "R6");
      for (int i = 0; i < 4; i++) rd_reg("R3");
      rd_reg("R2");
      rd_reg("R2");
      // R7: full pool, read plus incoming byte
      for (int i = 0; i < 4; i++) feed(8'hA0 + 8'(i), "R6");
      step(1, 0, REG, 32'h0, 1, 8'hAA, "R7");
      for (int i = 0; i < 5; i++) rd_reg("R7");
      // R4: flush with simultaneous byte, read during flush write
      feed(8'h31, "R4"); feed(8'h32, "R4");
      step(1, 1, REG, 32'h5000_0000, 1, 8'h33, "R4");
      rd_reg("R4");
      // R5: disable empties pool and blocks bytes
      feed(8'h41, "R5"); feed(8'h42, "R5");
      wr_reg(32'h0, "R5");
      feed(8'h43, "R5");
      rd_reg("R5");
      step(0, 1, REG, 32'h4000_0000, 1, 8'h44, "R5");
      rd_reg("R5");
      // R9: let LFSR produce, then read
      for (int i = 0; i < 20; i++) idle("R9");
      for (int i = 0; i < 3; i++) begin
         rd_reg("R9");
         repeat (8) idle("R9");
      end
      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit rd, wr, ev;
         logic [3:0] addr;
         logic [31:0] wd;
         rd = ($urandom % 3) == 0;
         wr = ($urandom % 40) == 0;
         ev = ($urandom % 2) == 0;
         addr = (($urandom % 10) == 0) ? 4'($urandom) : REG;
         wd = $urandom;
         wd[30] = ($urandom % 8) != 0;
         wd[28] = ($urandom % 4) == 0;
         step(rd, wr, addr, wd, ev, 8'($urandom), "R3,R6,R7,R9");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule